// File: doc/BRIEF.md
# ADC Conversion Scan Sequencer

This block is the digital control for an eight-input analog-to-digital converter. A start bit is set by a software pulse or by a qualified external trigger. The sequencer then chooses channels from an enable mask, hands each one to the converter as a one-cycle start with a selected input, and waits for the converter's done flag. It then files the returned code in that channel's data register. A conversion runs only while the converter-enable input is high.

Three operating modes exist. Single mode converts only the lowest enabled channel. Single-cycle scan makes one ascending pass over the enabled channels. Continuous scan repeats passes until software stops it. In the first two modes the start bit drops by itself when the work is done. Every completed conversion or pass can raise a one-cycle interrupt pulse and a one-cycle DMA request pulse. Differential operation pairs the inputs even/odd, and can store results as unsigned codes or as two's complement codes.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With `mode` = 2'b00 (single), a start converts only the lowest enabled channel, and `busy` returns to 0 by itself afterwards.
- R2: With `mode` = 2'b10 (single-cycle scan), the enabled channels are converted once each in ascending order and disabled ones are skipped. Each `cnv_start` lasts one cycle, and `busy` returns to 0 after the pass.
- R3: With `mode` = 2'b11 (continuous scan), passes repeat until `sw_start_clr` is pulsed. After that `busy` is 0 and no further `cnv_start` appears.
- R4: A start request is ignored while `conv_enable` is 0 or `mode` is the reserved code 2'b01, and no `cnv_start` is issued while `conv_enable` is 0.
- R5: When `trig_enable` is 1, `ext_trig` sets the start bit according to `trig_cond`: 00 low level, 01 high level, 10 falling edge, 11 rising edge. When `trig_enable` is 0, `ext_trig` has no effect.
- R6: When a single conversion or a scan pass completes, `irq` pulses for one cycle if `irq_enable` is 1, and `dma_req` pulses for one cycle if `dma_enable` is 1. Neither pulses when its enable is 0.
- R7: Each result is stored in the data register of the channel that was converted and sets that register's valid flag. A read (`rd_en` with `rd_chan`) returns the data, valid and overrun bits combinationally, and clears the valid flag at the next clock.
- R8: A result written while the channel's valid flag is still set raises its overrun flag. A read clears the overrun flag.
- R9: With `diff_mode` = 1, `cnv_diff` is 1 and `cnv_sel` names the even (positive) input of the converted channel's pair. If both members of a pair are enabled in a scan, the pair is converted twice and both data registers receive a result.
- R10: With `diff_mode` = 1 and `twos_fmt` = 1, the stored code is the raw code with its top bit inverted. Single-ended results are always stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_enable | input | 1 | Converter enable; gates every conversion |
| irq_enable | input | 1 | Enables the end-of-conversion interrupt pulse |
| dma_enable | input | 1 | Enables the DMA request pulse |
| mode | input | 2 | 00 single, 10 one scan pass, 11 continuous scan, 01 reserved |
| diff_mode | input | 1 | Pairs the inputs as differential pairs |
| twos_fmt | input | 1 | Stores differential results in two's complement |
| trig_enable | input | 1 | Lets the external trigger set the start bit |
| trig_cond | input | 2 | Trigger qualifier: low, high, falling, rising |
| ext_trig | input | 1 | External trigger line (asynchronous) |
| sw_start_set | input | 1 | Software pulse that sets the start bit |
| sw_start_clr | input | 1 | Software pulse that clears the start bit (wins over set) |
| chan_en | input | 8 | Channel enable mask |
| cnv_start | output | 1 | One-cycle start to the converter |
| cnv_sel | output | 3 | Input selected for the conversion |
| cnv_diff | output | 1 | Conversion is differential |
| cnv_done | input | 1 | Converter finished; `cnv_code` valid |
| cnv_code | input | 12 | Raw unsigned converter code |
| rd_en | input | 1 | Read strobe for a data register |
| rd_chan | input | 3 | Channel whose data register is read |
| rd_data | output | 12 | Stored code of `rd_chan` |
| rd_valid | output | 1 | Valid flag of `rd_chan` |
| rd_overrun | output | 1 | Overrun flag of `rd_chan` |
| busy | output | 1 | Start bit |
| irq | output | 1 | End-of-conversion interrupt pulse |
| dma_req | output | 1 | DMA transfer request pulse |

## Verification
The bench builds the block with its default parameters: eight channels, 12-bit codes and a two-stage trigger synchronizer. With eight channels there are four full differential pairs, and the top channel can be used, so the ascending search that ends a pass past channel 7 is exercised. With 12-bit codes, the top-bit inversion of the two's complement format shows up as a fixed 0x800 difference. The two-stage synchronizer adds delay before the trigger is qualified, so the trigger checks rely on counting the conversions that a trigger causes, not on edge-exact timing.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      MD_SINGLE = 2'b00,
      MD_RSVD   = 2'b01,
      MD_PASS   = 2'b10,
      MD_LOOP   = 2'b11
   } scan_mode_e;

   typedef enum logic [1:0] {
      TC_LOW  = 2'b00,
      TC_HIGH = 2'b01,
      TC_FALL = 2'b10,
      TC_RISE = 2'b11
   } trig_cond_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ISSUE,
      SQ_WAIT
   } seq_state_e;

endpackage

// File: rtl/adc_trig_detect.sv
module adc_trig_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trig_in,
   input  logic       enable,
   input  logic [1:0] cond,
   output logic       fire
);
   import adc_seq_pkg::*;

   logic lvl;
   logic lvl_prev;

   generate
      if (SYNC_STAGES < 0) begin : g_bad
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = trig_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= trig_in;
               for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
            end
         end
         assign lvl = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= 1'b0;
      else        lvl_prev <= lvl;
   end

   always_comb begin
      unique case (trig_cond_e'(cond))
         TC_LOW:  fire = enable & ~lvl;
         TC_HIGH: fire = enable &  lvl;
         TC_FALL: fire = enable &  lvl_prev & ~lvl;
         TC_RISE: fire = enable & ~lvl_prev &  lvl;
         default: fire = 1'b0;
      endcase
   end

   AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cond[1]) |=> (!fire || !$stable(cond)));   // R5

endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
   parameter int NCH  = 8,
   localparam int CH_W = $clog2(NCH)
) (
   input  logic [NCH-1:0]  mask,
   input  logic [CH_W:0]   from,
   output logic            found,
   output logic [CH_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (mask[i] && (i >= int'(from))) begin
            found = 1'b1;
            idx   = CH_W'(i);
         end
      end
   end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int NCH    = 8,
   parameter int CODE_W = 12,
   localparam int CH_W  = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_chan,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              rd_en,
   input  logic [CH_W-1:0]   rd_chan,
   output logic [CODE_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              rd_ovr
);
   logic [CODE_W-1:0] data_q [NCH];
   logic [NCH-1:0]    valid_q;
   logic [NCH-1:0]    ovr_q;

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_slot
         logic hit_wr;
         logic hit_rd;
         assign hit_wr = wr_en && (wr_chan == CH_W'(g));
         assign hit_rd = rd_en && (rd_chan == CH_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q[g]  <= '0;
               valid_q[g] <= 1'b0;
               ovr_q[g]   <= 1'b0;
            end else if (hit_wr) begin
               data_q[g]  <= wr_code;
               valid_q[g] <= 1'b1;
               ovr_q[g]   <= (ovr_q[g] | valid_q[g]) & ~hit_rd;
            end else if (hit_rd) begin
               valid_q[g] <= 1'b0;
               ovr_q[g]   <= 1'b0;
            end
         end

         AST_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovr_q[g]) |-> $past(valid_q[g]));   // R8
      end
   endgenerate

   assign rd_data  = data_q[rd_chan];
   assign rd_valid = valid_q[rd_chan];
   assign rd_ovr   = ovr_q[rd_chan];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int NCH         = 8,
   parameter int CODE_W      = 12,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_enable,
   input  logic              irq_enable,
   input  logic              dma_enable,
   input  logic [1:0]        mode,
   input  logic              diff_mode,
   input  logic              twos_fmt,
   input  logic              trig_enable,
   input  logic [1:0]        trig_cond,
   input  logic              ext_trig,
   input  logic              sw_start_set,
   input  logic              sw_start_clr,
   input  logic [NCH-1:0]    chan_en,
   output logic              cnv_start,
   output logic [CH_W-1:0]   cnv_sel,
   output logic              cnv_diff,
   input  logic              cnv_done,
   input  logic [CODE_W-1:0] cnv_code,
   input  logic              rd_en,
   input  logic [CH_W-1:0]   rd_chan,
   output logic [CODE_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              rd_overrun,
   output logic              busy,
   output logic              irq,
   output logic              dma_req
);
   import adc_seq_pkg::*;

   generate
      if (NCH < 2 || (NCH % 2) != 0 || NCH != (1 << CH_W)) begin : g_bad_nch
         $error("NCH must be an even power of two");
      end
      if (CODE_W < 2) begin : g_bad_code
         $error("CODE_W must be at least 2");
      end
   endgenerate

   scan_mode_e md;
   seq_state_e st;
   logic            run;
   logic [CH_W-1:0] cur;
   logic            trig_fire;
   logic            first_found, nxt_found;
   logic [CH_W-1:0] first_idx, nxt_idx;
   logic            mode_ok, start_req, done_ok, last_one, pass_end, hw_stop;
   logic [CODE_W-1:0] stored_code;

   assign md = scan_mode_e'(mode);

   adc_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk(clk), .rst_n(rst_n), .trig_in(ext_trig), .enable(trig_enable),
      .cond(trig_cond), .fire(trig_fire)
   );

   adc_chan_pick #(.NCH(NCH)) u_first (
      .mask(chan_en), .from('0), .found(first_found), .idx(first_idx)
   );

   adc_chan_pick #(.NCH(NCH)) u_next (
      .mask(chan_en), .from({1'b0, cur} + (CH_W+1)'(1)),
      .found(nxt_found), .idx(nxt_idx)
   );

   assign mode_ok   = (md != MD_RSVD);
   assign start_req = (sw_start_set | trig_fire) & conv_enable & mode_ok;
   assign done_ok   = (st == SQ_WAIT) && cnv_done;
   assign last_one  = (md == MD_SINGLE) || !nxt_found;
   assign pass_end  = done_ok && last_one;
   assign hw_stop   = pass_end && (md != MD_LOOP);

   // start bit: software clear wins, then any set, then hardware completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                run <= 1'b0;
      else if (sw_start_clr)     run <= 1'b0;
      else if (start_req)        run <= 1'b1;
      else if (hw_stop)          run <= 1'b0;
      else if (run && st == SQ_IDLE && !first_found && md != MD_LOOP)
                                 run <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SQ_IDLE;
         cur <= '0;
      end else if (sw_start_clr || !run) begin
         st <= SQ_IDLE;
      end else begin
         unique case (st)
            SQ_IDLE: begin
               if (conv_enable && first_found && mode_ok) begin
                  st  <= SQ_ISSUE;
                  cur <= first_idx;
               end
            end
            SQ_ISSUE: st <= SQ_WAIT;
            SQ_WAIT: begin
               if (cnv_done) begin
                  if (!last_one && conv_enable) begin
                     st  <= SQ_ISSUE;
                     cur <= nxt_idx;
                  end else if (last_one && md == MD_LOOP && conv_enable && first_found) begin
                     st  <= SQ_ISSUE;
                     cur <= first_idx;
                  end else begin
                     st <= SQ_IDLE;
                  end
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         dma_req <= 1'b0;
      end else begin
         irq     <= pass_end & irq_enable;
         dma_req <= pass_end & dma_enable;
      end
   end

   assign stored_code = (diff_mode && twos_fmt)
                        ? {~cnv_code[CODE_W-1], cnv_code[CODE_W-2:0]} : cnv_code;

   adc_result_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(done_ok), .wr_chan(cur),
      .wr_code(stored_code), .rd_en(rd_en), .rd_chan(rd_chan),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_ovr(rd_overrun)
   );

   assign cnv_start = (st == SQ_ISSUE);
   assign cnv_diff  = diff_mode;
   assign cnv_sel   = diff_mode ? {cur[CH_W-1:1], 1'b0} : cur;
   assign busy      = run;

   AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ok && md == MD_SINGLE && !sw_start_set && !trig_fire) |=> !busy);   // R1
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |=> !cnv_start);   // R2
   AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cnv_start);   // R3
   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |-> $past(conv_enable));   // R4

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int CW  = 12;
   localparam int CHW = 3;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic conv_enable, irq_enable, dma_enable, diff_mode, twos_fmt;
   logic trig_enable, ext_trig, sw_start_set, sw_start_clr, cnv_done, rd_en;
   logic [1:0] mode, trig_cond;
   logic [NCH-1:0] chan_en;
   logic [CW-1:0] cnv_code, rd_data;
   logic [CHW-1:0] cnv_sel, rd_chan;
   logic cnv_start, cnv_diff, rd_valid, rd_overrun, busy, irq, dma_req;

   adc_seq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .conv_enable(conv_enable), .irq_enable(irq_enable),
      .dma_enable(dma_enable), .mode(mode), .diff_mode(diff_mode), .twos_fmt(twos_fmt),
      .trig_enable(trig_enable), .trig_cond(trig_cond), .ext_trig(ext_trig),
      .sw_start_set(sw_start_set), .sw_start_clr(sw_start_clr), .chan_en(chan_en),
      .cnv_start(cnv_start), .cnv_sel(cnv_sel), .cnv_diff(cnv_diff),
      .cnv_done(cnv_done), .cnv_code(cnv_code), .rd_en(rd_en), .rd_chan(rd_chan),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_overrun(rd_overrun),
      .busy(busy), .irq(irq), .dma_req(dma_req)
   );

   int n_chk = 0, n_err = 0;
   int n_start = 0, n_irq = 0, n_dma = 0;
   logic [CHW-1:0] exp_sel_q[$];
   string exp_tag_q[$];

   function automatic logic [CW-1:0] code_of(logic [CHW-1:0] s);
      return {s, 9'h0C3};
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic expect_sel(logic [CHW-1:0] s, string tag);
      exp_sel_q.push_back(s);
      exp_tag_q.push_back(tag);
   endtask

   task automatic pulse_set();
      sw_start_set = 1'b1; step(); sw_start_set = 1'b0;
   endtask

   task automatic wait_idle(string tag);
      int n = 0;
      step();
      while (busy && n < 300) begin step(); n++; end
      if (n >= 300) chk({tag, " idle timeout"}, 1, 0);
      repeat (3) step();
   endtask

   task automatic do_read(logic [CHW-1:0] c, string tag, int e_data, int e_val, int e_ovr);
      rd_chan = c; rd_en = 1'b1;
      #1;
      if (e_data >= 0) chk({tag, " data"}, int'(rd_data), e_data);
      chk({tag, " valid"}, int'(rd_valid), e_val);
      chk({tag, " overrun"}, int'(rd_overrun), e_ovr);
      step();
      rd_en = 1'b0;
   endtask

   // converter model
   initial begin
      int cnt = 0;
      logic [CHW-1:0] lat_sel = '0;
      cnv_done = 1'b0;
      cnv_code = '0;
      forever begin
         @(negedge clk);
         cnv_done = 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin cnv_done = 1'b1; cnv_code = code_of(lat_sel); end
         end
         if (cnv_start === 1'b1) begin lat_sel = cnv_sel; cnt = LAT; end
      end
   end

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (cnv_start === 1'b1) begin
               n_start++;
               if (exp_sel_q.size() == 0) begin
                  chk("R4 unexpected cnv_start", 1, 0);
               end else begin
                  logic [CHW-1:0] s;
                  string t;
                  s = exp_sel_q.pop_front();
                  t = exp_tag_q.pop_front();
                  chk(t, int'(cnv_sel), int'(s));
                  if (t == "R9 pair") chk("R9 cnv_diff", int'(cnv_diff), 1);
               end
            end
            if (irq === 1'b1) n_irq++;
            if (dma_req === 1'b1) n_dma++;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog R3: act=hung exp=finished");
      finish_run();
   end

   initial begin
      int b_s, b_i, b_d;
      conv_enable = 1'b1; irq_enable = 1'b0; dma_enable = 1'b0; diff_mode = 1'b0;
      twos_fmt = 1'b0; trig_enable = 1'b0; ext_trig = 1'b0; sw_start_set = 1'b0;
      sw_start_clr = 1'b0; rd_en = 1'b0; mode = 2'b00; trig_cond = 2'b11;
      chan_en = '0; rd_chan = '0;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // reset state
      chk("R1 reset busy", int'(busy), 0);
      chk("R6 reset irq", int'(irq), 0);
      chk("R6 reset dma", int'(dma_req), 0);
      chk("R2 reset start", int'(cnv_start), 0);
      do_read(3'd0, "R7 reset", 0, 0, 0);

      // R1 single: lowest enabled only
      chan_en = 8'b0010_1100; mode = 2'b00; irq_enable = 1'b1;
      b_i = n_irq; b_d = n_dma;
      expect_sel(3'd2, "R1 single sel");
      pulse_set();
      chk("R1 busy set", int'(busy), 1);
      wait_idle("R1");
      chk("R1 busy self-clear", int'(busy), 0);
      chk("R6 irq count", n_irq - b_i, 1);
      chk("R6 no dma", n_dma - b_d, 0);
      do_read(3'd2, "R7 ch2", int'(code_of(3'd2)), 1, 0);
      do_read(3'd2, "R7 ch2 reread", -1, 0, 0);
      do_read(3'd3, "R1 ch3 untouched", -1, 0, 0);

      // R2 one scan pass
      irq_enable = 1'b0; dma_enable = 1'b1; mode = 2'b10; chan_en = 8'b1010_0101;
      b_i = n_irq; b_d = n_dma;
      expect_sel(3'd0, "R2 scan sel"); expect_sel(3'd2, "R2 scan sel");
      expect_sel(3'd5, "R2 scan sel"); expect_sel(3'd7, "R2 scan sel");
      pulse_set();
      wait_idle("R2");
      chk("R2 busy self-clear", int'(busy), 0);
      chk("R6 dma count", n_dma - b_d, 1);
      chk("R6 no irq", n_irq - b_i, 0);
      do_read(3'd5, "R7 ch5", int'(code_of(3'd5)), 1, 0);
      do_read(3'd7, "R7 ch7", int'(code_of(3'd7)), 1, 0);
      do_read(3'd0, "R7 ch0", int'(code_of(3'd0)), 1, 0);

      // R8 overrun: ch2 still unread, ch0 just read
      dma_enable = 1'b0; chan_en = 8'b0000_0101;
      expect_sel(3'd0, "R2 scan sel"); expect_sel(3'd2, "R2 scan sel");
      pulse_set();
      wait_idle("R8");
      do_read(3'd0, "R8 ch0", int'(code_of(3'd0)), 1, 0);
      do_read(3'd2, "R8 ch2", int'(code_of(3'd2)), 1, 1);
      do_read(3'd2, "R8 ch2 cleared", -1, 0, 0);

      // R3 continuous scan
      mode = 2'b11; chan_en = 8'b0100_0010;
      b_s = n_start;
      expect_sel(3'd1, "R3 loop sel"); expect_sel(3'd6, "R3 loop sel");
      expect_sel(3'd1, "R3 loop sel"); expect_sel(3'd6, "R3 loop sel");
      expect_sel(3'd1, "R3 loop sel");
      pulse_set();
      for (int k = 0; k < 400 && (n_start - b_s) < 5; k++) step();
      chk("R3 still running", int'(busy), 1);
      sw_start_clr = 1'b1; step(); sw_start_clr = 1'b0;
      repeat (20) step();
      chk("R3 stopped busy", int'(busy), 0);
      chk("R3 start count", n_start - b_s, 5);
      chk("R3 queue drained", exp_sel_q.size(), 0);

      // R4 gating
      conv_enable = 1'b0; mode = 2'b10; chan_en = 8'b0000_0001;
      b_s = n_start;
      pulse_set();
      repeat (10) step();
      chk("R4 disabled busy", int'(busy), 0);
      chk("R4 disabled starts", n_start - b_s, 0);
      conv_enable = 1'b1; mode = 2'b01;
      pulse_set();
      repeat (10) step();
      chk("R4 reserved busy", int'(busy), 0);
      chk("R4 reserved starts", n_start - b_s, 0);

      // R5 triggers
      mode = 2'b00; chan_en = 8'b1000_0000; trig_cond = 2'b11; trig_enable = 1'b0;
      b_s = n_start;
      ext_trig = 1'b1; repeat (3) step(); ext_trig = 1'b0;
      repeat (10) step();
      chk("R5 trigger off", n_start - b_s, 0);
      trig_enable = 1'b1;
      expect_sel(3'd7, "R5 rise sel");
      ext_trig = 1'b1; repeat (3) step(); ext_trig = 1'b0;
      repeat (8) step();
      wait_idle("R5 rise");
      chk("R5 rise count", n_start - b_s, 1);
      trig_enable = 1'b0; trig_cond = 2'b10; step(); trig_enable = 1'b1;
      ext_trig = 1'b1; repeat (10) step();
      chk("R5 falling ignores rise", n_start - b_s, 1);
      expect_sel(3'd7, "R5 fall sel");
      ext_trig = 1'b0; repeat (8) step();
      wait_idle("R5 fall");
      chk("R5 fall count", n_start - b_s, 2);
      trig_enable = 1'b0; trig_cond = 2'b01; step(); trig_enable = 1'b1;
      expect_sel(3'd7, "R5 high sel");
      ext_trig = 1'b1; repeat (2) step(); ext_trig = 1'b0;
      repeat (6) step();
      wait_idle("R5 high");
      chk("R5 high count", n_start - b_s, 3);
      trig_enable = 1'b0;
      do_read(3'd7, "R7 ch7 trig", int'(code_of(3'd7)), 1, 1);

      // R9 differential pairs
      diff_mode = 1'b1; twos_fmt = 1'b0; mode = 2'b10; chan_en = 8'b0011_1000;
      expect_sel(3'd2, "R9 pair"); expect_sel(3'd4, "R9 pair"); expect_sel(3'd4, "R9 pair");
      pulse_set();
      wait_idle("R9");
      do_read(3'd3, "R9 ch3", int'(code_of(3'd2)), 1, 0);
      do_read(3'd4, "R9 ch4", int'(code_of(3'd4)), 1, 0);
      do_read(3'd5, "R9 ch5", int'(code_of(3'd4)), 1, 0);

      // R10 two's complement format
      twos_fmt = 1'b1; mode = 2'b00; chan_en = 8'b0001_0000;
      expect_sel(3'd4, "R10 sel");
      pulse_set();
      wait_idle("R10 diff");
      do_read(3'd4, "R10 twos", int'(code_of(3'd4)) ^ 12'h800, 1, 0);
      diff_mode = 1'b0;
      expect_sel(3'd4, "R10 sel");
      pulse_set();
      wait_idle("R10 single-ended");
      do_read(3'd4, "R10 unsigned", int'(code_of(3'd4)), 1, 0);

      chk("R2 queue empty", exp_sel_q.size(), 0);
      finish_run();
   end
endmodule